// File: doc/BRIEF.md
# Circular Queue Pointer Controller

This block keeps the producer and consumer pointers of a ring buffer held in system memory. Software sets the buffer's base address and a run-time log2 depth. Each pointer is a 32-bit register. Its low log2 bits are the slot index. The bit just above the index is a wrap flag, and that flag is what separates a full ring from an empty one. From the two pointers the block derives full and empty flags and the byte address of the slot each pointer names.

The agent that owns a pointer pulses an increment strobe to advance it. The global enable gates both strobes. The consumer register also carries a 7-bit error field that a command processor can load. While that field is nonzero the consumer pointer cannot move. Software releases it by rewriting the consumer register with the field cleared. The entry size is a parameter: 16 bytes suits a command ring and 32 bytes suits an event ring.

Top module: `cq_ptr_ctrl`

## Requirements
- R1: After reset the base, the log2 depth and both pointer registers read zero, `empty` is 1 and `full` is 0.
- R2: A depth write stores the written value, except that values above LG_MAX (default 19) are stored as LG_MAX. `lg_rd` returns the stored value.
- R3: `empty` is 1 exactly when the two pointers agree in their low log2+1 bits. Bits above the wrap flag are ignored.
- R4: `full` is 1 exactly when the two indices (low log2 bits) match and the wrap flags (bit log2) differ.
- R5: A producer increment sets the producer register to (value+1) masked to its low log2+1 bits. The wrap flag therefore toggles on rollover, and every higher bit is cleared, including the overflow flag at bit 31.
- R6: A consumer increment replaces only the low log2+1 bits with those of (value+1). Bits above the wrap flag are kept unchanged.
- R7: A pulse on `err_set` writes `err_code` into consumer bits 30:24. Codes are 0 none, 1 illegal command, 2 abort, 3 invalidate-sync. While that field is nonzero, consumer increments are ignored. A consumer increment in the same cycle as `err_set` is still judged against the old field. A software consumer write in the same cycle as `err_set` takes precedence over it.
- R8: Each entry address equals the base with bits 5:0 cleared, plus ENTRY_BYTES (default 16) times the pointer's index.
- R9: While `q_en` is 0, both increment strobes are ignored.
- R10: When a register write and an increment of the same pointer fall in the same cycle, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_en | input | 1 | Queue enable, gates increments |
| base_we | input | 1 | Base address write strobe |
| base_wdata | input | ADDR_W | Base address write data |
| lg_we | input | 1 | Log2 depth write strobe |
| lg_wdata | input | LG_W | Log2 depth write data |
| prod_we | input | 1 | Producer register write strobe |
| prod_wdata | input | 32 | Producer write data |
| cons_we | input | 1 | Consumer register write strobe |
| cons_wdata | input | 32 | Consumer write data |
| err_set | input | 1 | Load error code into consumer register |
| err_code | input | 7 | Error code to load |
| prod_inc | input | 1 | Producer advance strobe |
| cons_inc | input | 1 | Consumer advance strobe |
| base_rd | output | ADDR_W | Stored base address |
| lg_rd | output | LG_W | Effective log2 depth |
| prod_rd | output | 32 | Producer register |
| cons_rd | output | 32 | Consumer register |
| full | output | 1 | Ring full |
| empty | output | 1 | Ring empty |
| prod_addr | output | ADDR_W | Address of producer slot |
| cons_addr | output | ADDR_W | Address of consumer slot |

## Verification
The bench drives the producer through a complete lap so that the index returns to zero with the wrap flag set. A design that compares indices only would report that state as empty instead of full. It also rolls a pointer whose register holds stray high bits: a producer that fails to mask would leave the overflow flag or carry bits behind, and a consumer that masks too much would wipe out the error field. Error blocking is checked by pulsing an increment while a code is pending and by setting a code in the same cycle as an increment; a design that tested the new field would drop that increment. The bench also writes a depth above the limit and then runs at the largest depth, where a missing clamp or a mask one bit too narrow would give the wrong full flag and the wrong rollover.

// File: rtl/cq_ptr_ctrl.sv
module cq_ptr_ctrl #(
  parameter int ADDR_W      = 48,
  parameter int LG_MAX      = 19,
  parameter int ENTRY_BYTES = 16,
  localparam int LG_W       = $clog2(LG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_en,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              lg_we,
  input  logic [LG_W-1:0]   lg_wdata,
  input  logic              prod_we,
  input  logic [31:0]       prod_wdata,
  input  logic              cons_we,
  input  logic [31:0]       cons_wdata,
  input  logic              err_set,
  input  logic [6:0]        err_code,
  input  logic              prod_inc,
  input  logic              cons_inc,
  output logic [ADDR_W-1:0] base_rd,
  output logic [LG_W-1:0]   lg_rd,
  output logic [31:0]       prod_rd,
  output logic [31:0]       cons_rd,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] prod_addr,
  output logic [ADDR_W-1:0] cons_addr
);
  localparam int ERR_LSB = 24;
  localparam int ERR_MSB = 30;
  localparam int ALIGN   = 6;

  logic [ADDR_W-1:0] base_q;
  logic [LG_W-1:0]   lg_q;
  logic [31:0]       prod_q, cons_q, prod_nx, cons_nx;
  logic [31:0]       wrap_m, idx_m, wi_m;
  logic [ADDR_W-1:0] base_al;
  logic              err_pend;

  assign wrap_m   = 32'd1 << lg_q;
  assign idx_m    = wrap_m - 32'd1;
  assign wi_m     = (wrap_m << 1) - 32'd1;
  assign err_pend = |cons_q[ERR_MSB:ERR_LSB];

  always_comb begin
    prod_nx = prod_q;
    if (q_en && prod_inc)
      prod_nx = (prod_q + 32'd1) & wi_m;
  end

  always_comb begin
    cons_nx = cons_q;
    if (q_en && cons_inc && !err_pend)
      cons_nx = (cons_q & ~wi_m) | ((cons_q + 32'd1) & wi_m);
    if (err_set)
      cons_nx[ERR_MSB:ERR_LSB] = err_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lg_q   <= '0;
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      if (lg_we)   lg_q   <= (lg_wdata > LG_W'(LG_MAX)) ? LG_W'(LG_MAX) : lg_wdata;
      prod_q <= prod_we ? prod_wdata : prod_nx;
      cons_q <= cons_we ? cons_wdata : cons_nx;
    end
  end

  assign base_al   = {base_q[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
  assign prod_addr = base_al + ADDR_W'(ENTRY_BYTES) * ADDR_W'(prod_q & idx_m);
  assign cons_addr = base_al + ADDR_W'(ENTRY_BYTES) * ADDR_W'(cons_q & idx_m);

  assign full  = ((prod_q ^ cons_q) & wi_m) == wrap_m;
  assign empty = ((prod_q ^ cons_q) & wi_m) == 32'd0;

  assign base_rd = base_q;
  assign lg_rd   = lg_q;
  assign prod_rd = prod_q;
  assign cons_rd = cons_q;
endmodule

// File: rtl/cq_ptr_ctrl_chk.sv
module cq_ptr_ctrl_chk #(
  parameter int LG_MAX = 19,
  parameter int LG_W   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            q_en,
  input logic            prod_we,
  input logic [31:0]     prod_wdata,
  input logic            cons_we,
  input logic            err_set,
  input logic            prod_inc,
  input logic [LG_W-1:0] lg_rd,
  input logic [31:0]     prod_rd,
  input logic [31:0]     cons_rd,
  input logic            full,
  input logic            empty
);
  assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_depth_clamped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lg_rd <= LG_W'(LG_MAX));

  assert_idle_prod_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_en && !prod_we) |=> $stable(prod_rd));

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_rd[30:24] != 7'd0 && !cons_we && !err_set) |=> $stable(cons_rd));

  assert_cons_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cons_we && !err_set) |=> cons_rd[31:LG_MAX+1] == $past(cons_rd[31:LG_MAX+1]));

  assert_prod_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_en && prod_inc && !prod_we) |=> prod_rd[31:LG_MAX+1] == '0);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prod_we |=> prod_rd == $past(prod_wdata));
endmodule

bind cq_ptr_ctrl cq_ptr_ctrl_chk #(.LG_MAX(LG_MAX), .LG_W(LG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_en(q_en), .prod_we(prod_we), .prod_wdata(prod_wdata),
  .cons_we(cons_we), .err_set(err_set), .prod_inc(prod_inc), .lg_rd(lg_rd),
  .prod_rd(prod_rd), .cons_rd(cons_rd), .full(full), .empty(empty)
);

// File: tb/cq_ptr_ctrl_tb.sv
module cq_ptr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 48;
  localparam int LG_W = 5;

  logic clk = 0, rst_n = 0, q_en = 0;
  logic base_we = 0, lg_we = 0, prod_we = 0, cons_we = 0, err_set = 0;
  logic prod_inc = 0, cons_inc = 0;
  logic [ADDR_W-1:0] base_wdata = '0;
  logic [LG_W-1:0] lg_wdata = '0;
  logic [31:0] prod_wdata = '0, cons_wdata = '0;
  logic [6:0] err_code = '0;
  logic [ADDR_W-1:0] base_rd, prod_addr, cons_addr;
  logic [LG_W-1:0] lg_rd;
  logic [31:0] prod_rd, cons_rd;
  logic full, empty;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string tag_q[$];
  int sel_q[$];
  logic [63:0] val_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cq_ptr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .q_en(q_en),
    .base_we(base_we), .base_wdata(base_wdata), .lg_we(lg_we), .lg_wdata(lg_wdata),
    .prod_we(prod_we), .prod_wdata(prod_wdata), .cons_we(cons_we), .cons_wdata(cons_wdata),
    .err_set(err_set), .err_code(err_code), .prod_inc(prod_inc), .cons_inc(cons_inc),
    .base_rd(base_rd), .lg_rd(lg_rd), .prod_rd(prod_rd), .cons_rd(cons_rd),
    .full(full), .empty(empty), .prod_addr(prod_addr), .cons_addr(cons_addr)
  );

  function automatic logic [63:0] pick(int sel);
    case (sel)
      0: return 64'(prod_rd);
      1: return 64'(cons_rd);
      2: return 64'(full);
      3: return 64'(empty);
      4: return 64'(prod_addr);
      5: return 64'(cons_addr);
      6: return 64'(lg_rd);
      default: return 64'(base_rd);
    endcase
  endfunction

  always @(negedge clk) begin
    while (sel_q.size() > 0) begin
      string t;
      int s;
      logic [63:0] v, a;
      t = tag_q.pop_front();
      s = sel_q.pop_front();
      v = val_q.pop_front();
      a = pick(s);
      n_run++;
      if (a !== v) begin
        n_fail++;
        $display("FAIL %s (sel %0d): actual %h expected %h", t, s, a, v);
      end
    end
  end

  task automatic chk(input string t, input int s, input logic [63:0] v);
    tag_q.push_back(t); sel_q.push_back(s); val_q.push_back(v);
  endtask

  task automatic step();
    @(posedge clk); #1;
    base_we = 0; lg_we = 0; prod_we = 0; cons_we = 0; err_set = 0;
    prod_inc = 0; cons_inc = 0;
  endtask

  task automatic wr_prod(input logic [31:0] v); prod_we = 1; prod_wdata = v; endtask
  task automatic wr_cons(input logic [31:0] v); cons_we = 1; cons_wdata = v; endtask
  task automatic wr_lg(input logic [LG_W-1:0] v); lg_we = 1; lg_wdata = v; endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 prod", 0, 0); chk("R1 cons", 1, 0); chk("R1 lg", 6, 0);
    chk("R1 full", 2, 0); chk("R1 empty", 3, 1); chk("R1 base", 7, 0);
    q_en = 1;

    wr_lg(5'd25); step(); chk("R2 clamp", 6, 19);
    wr_lg(5'd3);  step(); chk("R2 plain", 6, 3);

    for (int i = 0; i < 3; i++) begin prod_inc = 1; step(); end
    chk("R5 count", 0, 3); chk("R3 not empty", 3, 0); chk("R4 not full", 2, 0);
    for (int i = 0; i < 5; i++) begin prod_inc = 1; step(); end
    chk("R5 wrap set", 0, 8); chk("R4 full lap", 2, 1); chk("R3 lap not empty", 3, 0);
    prod_inc = 1; step(); chk("R5 past lap", 0, 9); chk("R4 clear", 2, 0);
    wr_prod(32'hF); step(); prod_inc = 1; step();
    chk("R5 rollover", 0, 0); chk("R3 empty again", 3, 1);
    wr_prod(32'h8000_0007); step(); prod_inc = 1; step();
    chk("R5 ovf cleared", 0, 8);

    wr_cons(32'h0012_0007); step(); cons_inc = 1; step();
    chk("R6 keep upper", 1, 32'h0012_0008);
    wr_cons(32'h0012_000F); step(); cons_inc = 1; step();
    chk("R6 rollover", 1, 32'h0012_0000);

    wr_prod(32'h5); wr_cons(32'h35); step();
    chk("R3 upper ignored", 3, 1); chk("R4 upper ignored", 2, 0);
    wr_cons(32'h3D); step();
    chk("R4 full upper", 2, 1); chk("R3 full not empty", 3, 0);

    wr_cons(32'h3); step();
    err_set = 1; err_code = 7'd2; step(); chk("R7 load", 1, 32'h0200_0003);
    cons_inc = 1; step(); chk("R7 blocked", 1, 32'h0200_0003);
    wr_cons(32'h3); step(); cons_inc = 1; step(); chk("R7 released", 1, 32'h4);
    err_set = 1; err_code = 7'd1; cons_inc = 1; step();
    chk("R7 same cycle", 1, 32'h0100_0005);
    wr_cons(32'h7); err_set = 1; err_code = 7'd3; step();
    chk("R7 write wins", 1, 32'h7);

    base_we = 1; base_wdata = 48'h1234_5678_9ABF; wr_prod(32'h5); wr_cons(32'hD); step();
    chk("R8 base", 7, 48'h1234_5678_9ABF);
    chk("R8 prod addr", 4, 48'h1234_5678_9AD0);
    chk("R8 cons addr", 5, 48'h1234_5678_9AD0);
    wr_prod(32'hE); step(); chk("R8 idx 6", 4, 48'h1234_5678_9AE0);

    q_en = 0; prod_inc = 1; cons_inc = 1; step();
    chk("R9 prod held", 0, 32'hE); chk("R9 cons held", 1, 32'hD);
    q_en = 1;

    wr_prod(32'h2); prod_inc = 1; step(); chk("R10 prod", 0, 2);
    wr_cons(32'h9); cons_inc = 1; step(); chk("R10 cons", 1, 9);

    wr_lg(5'd19); wr_prod(32'h7FFFF); wr_cons(32'h0); step();
    prod_inc = 1; step();
    chk("R5 max depth wrap", 0, 32'h80000); chk("R4 max depth full", 2, 1);
    wr_prod(32'hFFFFF); step(); prod_inc = 1; step();
    chk("R5 max rollover", 0, 0); chk("R3 max empty", 3, 1);

    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule